// File: doc/BRIEF.md
# Programmable Interval Counter Channel with Byte Port

This block is one channel of a programmable interval timer. It decodes control bytes written to a shared control strobe. A control byte either takes a snapshot of the running count or selects the channel's operating mode. The 16-bit count moves over an 8-bit data port in two accesses, low byte first and high byte second, in both directions.

After a full count has been written, the channel counts down by one on every input tick. When the count reaches zero it raises its output. In one-shot modes it then stops at zero. In periodic modes it reloads the value that was last written.

Writing the low byte stops the counter and pulls the output low. Both stay that way until the high byte completes the new value. A snapshot taken by a latch command stays held until both of its bytes have been read. While a snapshot is held, later latch commands leave it unchanged.

Top module: `interval_timer_chan`

## Requirements
- R1: After reset the count, snapshot and reload value are zero, no snapshot is held, both byte pointers select the low byte, `cnt_out` and `sel_err` are low, and two reads return 0x00 and then 0x00.
- R2: A control byte carries the channel select in bits 7:6, the access code in bits 5:4, the mode in bits 3:1 and the BCD flag in bit 0. A byte whose select is not the channel number (default 0) has no effect on the channel.
- R3: A control byte with select value 3 raises `sel_err` for exactly the cycle after it is written, and has no other effect.
- R4: A control byte for this channel with access code 00 copies the live count into the snapshot and returns the read pointer to the low byte, if no snapshot is held.
- R5: A latch command that arrives while a snapshot is held is ignored, and the first snapshot is kept.
- R6: Reads alternate between the low byte and the high byte. While a snapshot is held, reads return its bytes, and the snapshot is released after its high byte has been read.
- R7: When no snapshot is held, reads return the bytes of the live count, still alternating low then high.
- R8: Writing the low byte replaces bits 7:0 of the count, halts counting so that later ticks leave the count unchanged, makes `cnt_out` low from the next cycle, and moves the write pointer to the high byte.
- R9: Writing the high byte replaces bits 15:8 of the count, copies the full count into the reload value, returns the write pointer to the low byte, and starts counting.
- R10: While counting, each cycle with `tick` high decrements the count by one. On the tick that brings it to zero, `cnt_out` goes high. In one-shot modes (any mode other than 2 or 3) the count then stays at zero.
- R11: In periodic modes (mode 2 or 3, set by an access code other than 00), the tick that would bring the count to zero instead reloads it from the reload value, and `cnt_out` goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Write strobe for a control byte on `wdata` |
| data_we | input | 1 | Write strobe for a count byte on `wdata` |
| data_re | input | 1 | Read strobe; advances the read pointer at the clock edge |
| tick | input | 1 | Count enable, one decrement per high cycle |
| wdata | input | 8 | Control or count byte |
| rdata | output | 8 | Byte currently selected by the read pointer |
| cnt_out | output | 1 | Counter output |
| sel_err | output | 1 | One-cycle flag for an unsupported select value |

## Verification
`rdata` is combinational from the held state. It is valid in the same cycle as the `data_re` pulse that consumes it, and the read pointer advances at that cycle's closing edge. Control bytes, count writes and ticks change the state at the first clock edge after their strobe. Both `sel_err` and a change of `cnt_out` are therefore visible one cycle after the stimulus.

The bench drives every strobe on the falling clock edge. Read bytes are compared two time units after that falling edge, while the strobe is still high. All other outputs are checked at the falling edge that follows the rising edge on which the strobe was sampled.

// File: rtl/itc_pkg.sv
package itc_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int SEL_W  = 2;
    localparam int ACC_W  = 2;
    localparam int MODE_W = 3;

    // control byte layout: select on top, then access, mode, bcd flag
    localparam int SEL_LSB  = BYTE_W - SEL_W;
    localparam int ACC_LSB  = SEL_LSB - ACC_W;
    localparam int MODE_LSB = ACC_LSB - MODE_W;

    localparam logic [SEL_W-1:0]  SEL_READBACK = '1;
    localparam logic [ACC_W-1:0]  ACC_LATCH    = '0;
    localparam logic [MODE_W-1:0] MODE_RATE    = 3'd2;
    localparam logic [MODE_W-1:0] MODE_SQUARE  = 3'd3;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] period;
        logic             wptr_hi;
        logic             running;
        logic             out;
        logic             periodic;
    } cnt_state_t;

    typedef struct packed {
        logic             latched;
        logic [CNT_W-1:0] snap;
        logic             rptr_hi;
    } rd_state_t;
endpackage

// File: rtl/itc_ctrl_decode.sv
module itc_ctrl_decode
    import itc_pkg::*;
#(
    parameter logic [SEL_W-1:0] CHAN_ID = '0
) (
    input  logic              ctrl_we,
    input  logic [BYTE_W-1:1] ctrl_bits,
    output logic              latch_cmd,
    output logic              mode_wr,
    output logic              periodic,
    output logic              rb_err
);
    logic [SEL_W-1:0]  sel;
    logic [ACC_W-1:0]  acc;
    logic [MODE_W-1:0] mode;
    logic              hit;

    always_comb begin
        sel       = ctrl_bits[BYTE_W-1:SEL_LSB];
        acc       = ctrl_bits[SEL_LSB-1:ACC_LSB];
        mode      = ctrl_bits[ACC_LSB-1:MODE_LSB];
        hit       = ctrl_we && (sel == CHAN_ID) && (sel != SEL_READBACK);
        latch_cmd = hit && (acc == ACC_LATCH);
        mode_wr   = hit && (acc != ACC_LATCH);
        periodic  = (mode == MODE_RATE) || (mode == MODE_SQUARE);
        rb_err    = ctrl_we && (sel == SEL_READBACK);
    end
endmodule

// File: rtl/itc_counter.sv
module itc_counter
    import itc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic              tick,
    input  logic              mode_wr,
    input  logic              periodic_in,
    output logic [CNT_W-1:0]  count,
    output logic              wptr_hi,
    output logic              cnt_out
);
    cnt_state_t st_d, st_q;
    logic [CNT_W-1:0] dec;

    always_comb begin
        st_d = st_q;
        dec  = st_q.count - 1'b1;
        if (mode_wr) begin
            st_d.periodic = periodic_in;
        end
        if (wr_lo) begin
            st_d.count[BYTE_W-1:0] = wbyte;
            st_d.running           = 1'b0;
            st_d.out               = 1'b0;
            st_d.wptr_hi           = 1'b1;
        end else if (wr_hi) begin
            st_d.count[CNT_W-1:BYTE_W] = wbyte;
            st_d.period                = {wbyte, st_q.count[BYTE_W-1:0]};
            st_d.running               = 1'b1;
            st_d.wptr_hi               = 1'b0;
        end else if (tick && st_q.running) begin
            if (dec == '0) begin
                st_d.out = 1'b1;
                if (st_q.periodic) begin
                    st_d.count = st_q.period;
                end else begin
                    st_d.count   = '0;
                    st_d.running = 1'b0;
                end
            end else begin
                st_d.count = dec;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count   = st_q.count;
    assign wptr_hi = st_q.wptr_hi;
    assign cnt_out = st_q.out;
endmodule

// File: rtl/itc_read_port.sv
module itc_read_port
    import itc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_cmd,
    input  logic              rd,
    input  logic [CNT_W-1:0]  count,
    output logic [BYTE_W-1:0] rdata,
    output logic              latched,
    output logic [CNT_W-1:0]  snap
);
    rd_state_t st_d, st_q;
    logic [CNT_W-1:0] src;

    always_comb begin
        st_d = st_q;
        if (latch_cmd) begin
            if (!st_q.latched) begin
                st_d.latched = 1'b1;
                st_d.snap    = count;
                st_d.rptr_hi = 1'b0;
            end
        end else if (rd) begin
            if (st_q.rptr_hi) begin
                st_d.rptr_hi = 1'b0;
                st_d.latched = 1'b0;
            end else begin
                st_d.rptr_hi = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        src   = st_q.latched ? st_q.snap : count;
        rdata = st_q.rptr_hi ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
    end

    assign latched = st_q.latched;
    assign snap    = st_q.snap;
endmodule

// File: rtl/interval_timer_chan.sv
module interval_timer_chan
    import itc_pkg::*;
#(
    parameter logic [SEL_W-1:0] CHAN_ID = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              data_we,
    input  logic              data_re,
    input  logic              tick,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              cnt_out,
    output logic              sel_err
);
    logic             latch_cmd, mode_wr, periodic, rb_err;
    logic             wptr_hi, wr_lo, wr_hi, latched;
    logic [CNT_W-1:0] count, snap;
    logic             sel_err_d, sel_err_q;

    itc_ctrl_decode #(.CHAN_ID(CHAN_ID)) u_dec (
        .ctrl_we   (ctrl_we),
        .ctrl_bits (wdata[BYTE_W-1:1]),
        .latch_cmd (latch_cmd),
        .mode_wr   (mode_wr),
        .periodic  (periodic),
        .rb_err    (rb_err)
    );

    assign wr_lo = data_we && !wptr_hi;
    assign wr_hi = data_we && wptr_hi;

    itc_counter u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_lo       (wr_lo),
        .wr_hi       (wr_hi),
        .wbyte       (wdata),
        .tick        (tick),
        .mode_wr     (mode_wr),
        .periodic_in (periodic),
        .count       (count),
        .wptr_hi     (wptr_hi),
        .cnt_out     (cnt_out)
    );

    itc_read_port u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_cmd (latch_cmd),
        .rd        (data_re),
        .count     (count),
        .rdata     (rdata),
        .latched   (latched),
        .snap      (snap)
    );

    always_comb begin
        sel_err_d = rb_err;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_err_q <= 1'b0;
        end else begin
            sel_err_q <= sel_err_d;
        end
    end

    assign sel_err = sel_err_q;
endmodule

// File: rtl/itc_chk.sv
module itc_chk
    import itc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ctrl_we,
    input logic              tick,
    input logic [BYTE_W-1:0] wdata,
    input logic              cnt_out,
    input logic              sel_err,
    input logic              wr_lo,
    input logic              wr_hi,
    input logic [CNT_W-1:0]  count,
    input logic              latch_cmd,
    input logic              latched,
    input logic [CNT_W-1:0]  snap
);
    // R3
    readback_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && wdata[BYTE_W-1:SEL_LSB] == SEL_READBACK) |=> sel_err);

    // R8
    lo_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (!cnt_out && count[BYTE_W-1:0] == $past(wdata)
                   && count[CNT_W-1:BYTE_W] == $past(count[CNT_W-1:BYTE_W])));

    // R9
    hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> count == {$past(wdata), $past(count[BYTE_W-1:0])});

    // R4
    latch_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_cmd && !latched) |=> (latched && snap == $past(count)));

    // R5
    latch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_cmd && latched) |=> (latched && snap == $past(snap)));

    // R10
    out_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnt_out) |-> $past(tick));
endmodule

bind interval_timer_chan itc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_we   (ctrl_we),
    .tick      (tick),
    .wdata     (wdata),
    .cnt_out   (cnt_out),
    .sel_err   (sel_err),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .count     (count),
    .latch_cmd (latch_cmd),
    .latched   (latched),
    .snap      (snap)
);

// File: tb/interval_timer_chan_tb_top.sv
module interval_timer_chan_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_we = 1'b0;
    logic       data_we = 1'b0;
    logic       data_re = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       cnt_out;
    logic       sel_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    interval_timer_chan dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_we (ctrl_we),
        .data_we (data_we),
        .data_re (data_re),
        .tick    (tick),
        .wdata   (wdata),
        .rdata   (rdata),
        .cnt_out (cnt_out),
        .sel_err (sel_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: compares each read byte against the scoreboard queue
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (data_re) begin
                exp_t e;
                if (exp_q.size() == 0) begin
                    check(1'b0, "SCOREBOARD_EMPTY", rdata, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(rdata == e.val, e.tag, rdata, e.val);
                end
            end
        end
    end

    task automatic ctrl(input logic [7:0] b);
        @(negedge clk);
        ctrl_we = 1'b1;
        wdata   = b;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge clk);
        data_we = 1'b1;
        wdata   = b;
        @(negedge clk);
        data_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] exp, input string tag);
        exp_t e;
        e.val = exp;
        e.tag = tag;
        @(negedge clk);
        exp_q.push_back(e);
        data_re = 1'b1;
        @(negedge clk);
        data_re = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL WATCHDOG actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cnt_out == 1'b0, "R1 cnt_out", cnt_out, 0);
        check(sel_err == 1'b0, "R1 sel_err", sel_err, 0);
        rd(8'h00, "R1 low byte");
        rd(8'h00, "R1 high byte");

        // one-shot load of 5
        ctrl(8'h30);
        wr(8'h05);
        check(cnt_out == 1'b0, "R8 out low", cnt_out, 0);
        wr(8'h00);
        rd(8'h05, "R9 live low");
        rd(8'h00, "R9 live high");
        ticks(2);
        ctrl(8'h00);                    // R4 snapshot of 3
        ticks(1);
        ctrl(8'h00);                    // R5 ignored while held
        ticks(1);
        rd(8'h03, "R5 first snapshot low");
        rd(8'h00, "R6 snapshot high");
        rd(8'h01, "R7 live low after release");
        rd(8'h00, "R7 live high");
        ticks(1);
        check(cnt_out == 1'b1, "R10 out high at zero", cnt_out, 1);
        ticks(2);
        rd(8'h00, "R10 stays zero low");
        rd(8'h00, "R10 stays zero high");
        check(cnt_out == 1'b1, "R10 out stays high", cnt_out, 1);

        // latch resets the read pointer
        wr(8'h34);
        check(cnt_out == 1'b0, "R8 out low again", cnt_out, 0);
        rd(8'h34, "R8 low byte replaced");
        ctrl(8'h00);
        wr(8'h12);
        rd(8'h34, "R4 pointer back to low");
        rd(8'h00, "R4 snapshot high");
        rd(8'h34, "R9 live low");
        rd(8'h12, "R9 live high");

        // low write halts counting
        ticks(1);
        wr(8'h10);
        ticks(3);
        rd(8'h10, "R8 halted low");
        rd(8'h12, "R8 halted high");
        wr(8'h00);

        // periodic mode 2, load 3
        ctrl(8'h34);
        wr(8'h03);
        wr(8'h00);
        ticks(2);
        check(cnt_out == 1'b0, "R11 out low before terminal", cnt_out, 0);
        ticks(1);
        check(cnt_out == 1'b1, "R11 out high at terminal", cnt_out, 1);
        rd(8'h03, "R11 reloaded low");
        rd(8'h00, "R11 reloaded high");
        ticks(1);
        rd(8'h02, "R11 counting on low");
        rd(8'h00, "R11 counting on high");

        // other channel commands
        ctrl(8'h40);
        ticks(1);
        rd(8'h01, "R2 other latch ignored low");
        rd(8'h00, "R2 other latch ignored high");
        ctrl(8'h70);
        ticks(1);
        rd(8'h03, "R2 other mode ignored low");
        rd(8'h00, "R2 other mode ignored high");

        // read-back select
        ctrl(8'hC0);
        check(sel_err == 1'b1, "R3 sel_err pulse", sel_err, 1);
        @(negedge clk);
        check(sel_err == 1'b0, "R3 sel_err one cycle", sel_err, 0);
        ticks(1);
        rd(8'h02, "R3 no latch taken low");
        rd(8'h00, "R3 no latch taken high");

        @(negedge clk);
        check(exp_q.size() == 0, "SCOREBOARD_DRAIN", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule